// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Age-Ordered Select

This block is the scheduling window that sits between rename and register read in an out-of-order core. Each cycle it accepts at most one renamed instruction into a free slot. The instruction carries an opcode, two source physical tags with their availability flags, a destination tag and an immediate. Producers announce completion by driving their destination tags on a set of broadcast lanes. Each waiting operand compares its tag against every lane and marks itself available on a match.

Once both operands of a slot are available, the slot raises a request. A select stage grants up to a fixed number of requests per cycle, oldest instruction first. It presents each granted instruction on an issue lane and frees the slot in that same cycle. A broadcast only updates state at the clock edge, so an instruction being written on that edge would miss it. To cover this, the queue logs the broadcast tags and the index of the slot it just filled, and replays the comparison against that slot one cycle later. A flush input empties the window.

Top module: `iw_issue_queue`

## Requirements
- R1: After reset the window is empty: `disp_ready` is 1 and every bit of `iss_valid` is 0.
- R2: A dispatched instruction whose two operands are both flagged available is issued in the cycle after the edge that stores it. The issue lane shows its opcode, source tags, destination tag and immediate unchanged.
- R3: A valid broadcast on any lane sets the availability of every stored operand with an equal tag. An instruction woken this way is issued in the cycle after the broadcast cycle. Two lanes carrying two different tags in one cycle wake two different instructions.
- R4: An instruction is issued only while it is stored and both its operands are available. An instruction with an operand still pending is never issued.
- R5: Up to `NGNT` instructions issue per cycle, each from a distinct slot. Lane 0 carries the oldest requesting instruction in dispatch order, lane 1 the next oldest, and so on, whatever slot indices they occupy.
- R6: A slot is released in the cycle it is issued. The same instruction never appears on an issue lane in the following cycle.
- R7: When a broadcast arrives in the same cycle as a dispatch whose operand carries that tag, the operand is still marked available one cycle later. The instruction issues in the second cycle after its storing edge.
- R8: `disp_ready` is 0 while all `DEPTH` slots are occupied. A dispatch offered in that state is discarded and never issues.
- R9: A `flush` clears every slot at the next edge, and a dispatch offered in the flush cycle is discarded. In the following cycle nothing issues, `disp_ready` is 1, and later broadcasts wake nothing.
- R10: A broadcast lane whose valid bit is 0 wakes no operand, even when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the window at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_src1 | input | TAG_W | First source physical tag |
| disp_rdy1 | input | 1 | First source already available |
| disp_src2 | input | TAG_W | Second source physical tag |
| disp_rdy2 | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination physical tag |
| disp_imm | input | IMM_W | Immediate |
| disp_ready | output | 1 | At least one free slot |
| bc_valid | input | NBC | Per-lane broadcast valid |
| bc_tag | input | NBC*TAG_W | Broadcast tags, lane b at bits b*TAG_W |
| iss_valid | output | NGNT | Per-lane issue valid |
| iss_slot | output | NGNT*IDX_W | Slot index of each issued instruction |
| iss_op | output | NGNT*OP_W | Issued opcodes |
| iss_src1 | output | NGNT*TAG_W | Issued first source tags |
| iss_src2 | output | NGNT*TAG_W | Issued second source tags |
| iss_dst | output | NGNT*TAG_W | Issued destination tags |
| iss_imm | output | NGNT*IMM_W | Issued immediates |

## Verification
The properties assume that rename never hands out a destination tag that is still pending in the window twice. They also assume that broadcast tags belong to instructions that really produce them, so a wakeup always refers to a single in-flight value. The directed scenarios respect this by giving every producer tag a fresh value within a scenario and draining the window before the next scenario starts. Dispatch is offered while the window is full only as a deliberate probe of the discard rule, and that instruction's destination tag is not reused anywhere else.

// File: rtl/iw_pkg.sv
package iw_pkg;

    localparam int TAG_W = 6;
    localparam int OP_W  = 5;
    localparam int IMM_W = 12;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        tag_t             src1;
        logic             rdy1;
        tag_t             src2;
        logic             rdy2;
        tag_t             dst;
        logic [IMM_W-1:0] imm;
    } iw_entry_t;

    function automatic logic tag_hit(tag_t mine, logic lane_vld, tag_t lane_tag);
        return lane_vld && (mine == lane_tag);
    endfunction

endpackage

// File: rtl/iw_wakeup.sv
module iw_wakeup import iw_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int NBC   = 2,
    parameter int IDX_W = 3
) (
    input  tag_t                 src1 [DEPTH],
    input  tag_t                 src2 [DEPTH],
    input  logic [NBC-1:0]       bc_valid,
    input  logic [NBC*TAG_W-1:0] bc_tag,
    input  logic                 lg_vld,
    input  logic [IDX_W-1:0]     lg_idx,
    input  logic [NBC-1:0]       lg_bcv,
    input  logic [NBC*TAG_W-1:0] lg_tag,
    output logic [DEPTH-1:0]     hit1,
    output logic [DEPTH-1:0]     hit2
);
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit1[i] = 1'b0;
            hit2[i] = 1'b0;
            for (int b = 0; b < NBC; b++) begin
                hit1[i] = hit1[i] | tag_hit(src1[i], bc_valid[b], bc_tag[b*TAG_W +: TAG_W]);
                hit2[i] = hit2[i] | tag_hit(src2[i], bc_valid[b], bc_tag[b*TAG_W +: TAG_W]);
                if (lg_vld && (lg_idx == IDX_W'(i))) begin
                    hit1[i] = hit1[i] | tag_hit(src1[i], lg_bcv[b], lg_tag[b*TAG_W +: TAG_W]);
                    hit2[i] = hit2[i] | tag_hit(src2[i], lg_bcv[b], lg_tag[b*TAG_W +: TAG_W]);
                end
            end
        end
    end
endmodule

// File: rtl/iw_age.sv
module iw_age #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    output logic [DEPTH-1:0] older [DEPTH]
);
    // older[i][j] = 1 : slot i was written before slot j
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) older[i] <= '0;
        end else if (ins_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (IDX_W'(j) != ins_idx) begin
                    older[j][ins_idx] <= 1'b1;
                    older[ins_idx][j] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/iw_select.sv
module iw_select #(
    parameter int DEPTH = 8,
    parameter int NGNT  = 2,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] req,
    input  logic [DEPTH-1:0] older [DEPTH],
    output logic [NGNT-1:0]  gnt_vld,
    output logic [IDX_W-1:0] gnt_idx [NGNT]
);
    logic [DEPTH-1:0] pool [NGNT+1];
    logic [DEPTH-1:0] win  [NGNT];

    always_comb begin
        pool[0] = req;
        for (int k = 0; k < NGNT; k++) begin
            gnt_idx[k] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                logic beaten;
                beaten = 1'b0;
                for (int j = 0; j < DEPTH; j++)
                    beaten = beaten | (pool[k][j] & older[j][i]);
                win[k][i] = pool[k][i] & ~beaten;
                if (win[k][i]) gnt_idx[k] = IDX_W'(i);
            end
            gnt_vld[k]  = |win[k];
            pool[k+1]   = pool[k] & ~win[k];
        end
    end
endmodule

// File: rtl/iw_issue_queue.sv
module iw_issue_queue import iw_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int NBC   = 2,
    parameter int NGNT  = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  disp_valid,
    input  logic [OP_W-1:0]       disp_op,
    input  logic [TAG_W-1:0]      disp_src1,
    input  logic                  disp_rdy1,
    input  logic [TAG_W-1:0]      disp_src2,
    input  logic                  disp_rdy2,
    input  logic [TAG_W-1:0]      disp_dst,
    input  logic [IMM_W-1:0]      disp_imm,
    output logic                  disp_ready,
    input  logic [NBC-1:0]        bc_valid,
    input  logic [NBC*TAG_W-1:0]  bc_tag,
    output logic [NGNT-1:0]       iss_valid,
    output logic [NGNT*IDX_W-1:0] iss_slot,
    output logic [NGNT*OP_W-1:0]  iss_op,
    output logic [NGNT*TAG_W-1:0] iss_src1,
    output logic [NGNT*TAG_W-1:0] iss_src2,
    output logic [NGNT*TAG_W-1:0] iss_dst,
    output logic [NGNT*IMM_W-1:0] iss_imm
);
    iw_entry_t          ent_q [DEPTH];
    logic [DEPTH-1:0]   vld_q;
    tag_t               s1_v [DEPTH];
    tag_t               s2_v [DEPTH];
    logic [DEPTH-1:0]   hit1, hit2, req;
    logic [DEPTH-1:0]   older [DEPTH];
    logic [NGNT-1:0]    gnt_vld;
    logic [IDX_W-1:0]   gnt_idx [NGNT];
    logic [IDX_W-1:0]   free_idx;
    logic               disp_fire;

    // one-cycle log for the second wakeup pass
    logic               lg_vld;
    logic [IDX_W-1:0]   lg_idx;
    logic [NBC-1:0]     lg_bcv;
    logic [NBC*TAG_W-1:0] lg_tag;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!vld_q[i]) free_idx = IDX_W'(i);
    end

    assign disp_ready = ~&vld_q;
    assign disp_fire  = disp_valid & disp_ready & ~flush;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign s1_v[i] = ent_q[i].src1;
        assign s2_v[i] = ent_q[i].src2;
        assign req[i]  = vld_q[i] & ent_q[i].rdy1 & ent_q[i].rdy2;
    end

    iw_wakeup #(.DEPTH(DEPTH), .NBC(NBC), .IDX_W(IDX_W)) u_wake (
        .src1(s1_v), .src2(s2_v),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .lg_vld(lg_vld), .lg_idx(lg_idx), .lg_bcv(lg_bcv), .lg_tag(lg_tag),
        .hit1(hit1), .hit2(hit2)
    );

    iw_age #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_age (
        .clk(clk), .rst(rst), .ins_en(disp_fire), .ins_idx(free_idx), .older(older)
    );

    iw_select #(.DEPTH(DEPTH), .NGNT(NGNT), .IDX_W(IDX_W)) u_sel (
        .req(req), .older(older), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_q[i].rdy1 <= ent_q[i].rdy1 | hit1[i];
            ent_q[i].rdy2 <= ent_q[i].rdy2 | hit2[i];
        end
        if (disp_fire)
            ent_q[free_idx] <= '{op: disp_op, src1: disp_src1, rdy1: disp_rdy1,
                                 src2: disp_src2, rdy2: disp_rdy2, dst: disp_dst,
                                 imm: disp_imm};
    end

    // occupancy and replay log
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            lg_vld <= 1'b0;
            lg_idx <= '0;
            lg_bcv <= '0;
            lg_tag <= '0;
        end else begin
            for (int k = 0; k < NGNT; k++)
                if (gnt_vld[k]) vld_q[gnt_idx[k]] <= 1'b0;
            if (disp_fire) vld_q[free_idx] <= 1'b1;
            if (flush) vld_q <= '0;
            lg_vld <= disp_fire;
            lg_idx <= free_idx;
            lg_bcv <= bc_valid;
            lg_tag <= bc_tag;
        end
    end

    for (genvar k = 0; k < NGNT; k++) begin : g_iss
        assign iss_valid[k]                   = gnt_vld[k];
        assign iss_slot[k*IDX_W +: IDX_W]     = gnt_idx[k];
        assign iss_op[k*OP_W +: OP_W]         = ent_q[gnt_idx[k]].op;
        assign iss_src1[k*TAG_W +: TAG_W]     = ent_q[gnt_idx[k]].src1;
        assign iss_src2[k*TAG_W +: TAG_W]     = ent_q[gnt_idx[k]].src2;
        assign iss_dst[k*TAG_W +: TAG_W]      = ent_q[gnt_idx[k]].dst;
        assign iss_imm[k*IMM_W +: IMM_W]      = ent_q[gnt_idx[k]].imm;
    end
endmodule

// File: rtl/iw_issue_queue_chk.sv
module iw_issue_queue_chk #(
    parameter int DEPTH = 8,
    parameter int NGNT  = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  flush,
    input logic [DEPTH-1:0]      req_vec,
    input logic [NGNT-1:0]       iss_valid,
    input logic [NGNT*IDX_W-1:0] iss_slot,
    input logic                  disp_ready
);
    for (genvar k = 0; k < NGNT; k++) begin : g_k
        // R4: only a requesting slot may be granted
        a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
            iss_valid[k] |-> req_vec[iss_slot[k*IDX_W +: IDX_W]]);

        for (genvar j = 0; j < NGNT; j++) begin : g_j
            if (j > k) begin : g_pair
                // R5: lanes never share a slot
                a_r5_distinct_slots: assert property (@(posedge clk) disable iff (rst)
                    (iss_valid[k] && iss_valid[j]) |->
                    (iss_slot[k*IDX_W +: IDX_W] != iss_slot[j*IDX_W +: IDX_W]));
            end
            // R6: a granted slot is not granted again in the next cycle
            a_r6_no_regrant: assert property (@(posedge clk) disable iff (rst)
                iss_valid[k] |=> !(iss_valid[j] &&
                    iss_slot[j*IDX_W +: IDX_W] == $past(iss_slot[k*IDX_W +: IDX_W])));
        end
    end

    // R9: flush leaves an empty window behind
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (iss_valid == '0) && disp_ready);
endmodule

bind iw_issue_queue iw_issue_queue_chk #(.DEPTH(DEPTH), .NGNT(NGNT)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .req_vec(req),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .disp_ready(disp_ready)
);

// File: tb/iw_issue_queue_test.sv
module iw_issue_queue_test;
    import iw_pkg::*;

    localparam int DEPTH = 8;
    localparam int NBC   = 2;
    localparam int NGNT  = 2;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    logic disp_valid = 1'b0;
    logic [OP_W-1:0] disp_op = '0;
    logic [TAG_W-1:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
    logic disp_rdy1 = 1'b0, disp_rdy2 = 1'b0;
    logic [IMM_W-1:0] disp_imm = '0;
    logic disp_ready;
    logic [NBC-1:0] bc_valid = '0;
    logic [NBC*TAG_W-1:0] bc_tag = '0;
    logic [NGNT-1:0] iss_valid;
    logic [NGNT*IDX_W-1:0] iss_slot;
    logic [NGNT*OP_W-1:0] iss_op;
    logic [NGNT*TAG_W-1:0] iss_src1, iss_src2, iss_dst;
    logic [NGNT*IMM_W-1:0] iss_imm;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    iw_issue_queue #(.DEPTH(DEPTH), .NBC(NBC), .NGNT(NGNT)) uut (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_src1(disp_src1), .disp_rdy1(disp_rdy1),
        .disp_src2(disp_src2), .disp_rdy2(disp_rdy2),
        .disp_dst(disp_dst), .disp_imm(disp_imm), .disp_ready(disp_ready),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_op(iss_op),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_dst(iss_dst), .iss_imm(iss_imm)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 1'b0;
        bc_valid   = '0;
        flush      = 1'b0;
    endtask

    task automatic put(logic [OP_W-1:0] op, logic [TAG_W-1:0] s1, logic r1,
                       logic [TAG_W-1:0] s2, logic r2, logic [TAG_W-1:0] d,
                       logic [IMM_W-1:0] im);
        disp_valid = 1'b1; disp_op = op;
        disp_src1 = s1; disp_rdy1 = r1;
        disp_src2 = s2; disp_rdy2 = r2;
        disp_dst = d; disp_imm = im;
    endtask

    task automatic bcast(int lane, logic [TAG_W-1:0] t, logic v);
        bc_valid[lane] = v;
        bc_tag[lane*TAG_W +: TAG_W] = t;
    endtask

    function automatic logic [TAG_W-1:0] dst_of(int k);
        return iss_dst[k*TAG_W +: TAG_W];
    endfunction

    task automatic t_reset();
        chk("R1 disp_ready", 32'(disp_ready), 1);
        chk("R1 iss_valid", 32'(iss_valid), 0);
    endtask

    task automatic t_ready_dispatch();
        put(5'd3, 6'd5, 1'b1, 6'd6, 1'b1, 6'd9, 12'h321);
        tick(); idle();
        chk("R2 issue", 32'(iss_valid), 32'b01);
        chk("R2 op", 32'(iss_op[0 +: OP_W]), 3);
        chk("R2 src1", 32'(iss_src1[0 +: TAG_W]), 5);
        chk("R2 src2", 32'(iss_src2[0 +: TAG_W]), 6);
        chk("R2 dst", 32'(dst_of(0)), 9);
        chk("R2 imm", 32'(iss_imm[0 +: IMM_W]), 32'h321);
        tick();
        chk("R6 released", 32'(iss_valid), 0);
    endtask

    task automatic t_wakeup_two_lanes();
        put(5'd1, 6'd10, 1'b0, 6'd3, 1'b1, 6'd11, 12'h0);
        tick();
        put(5'd2, 6'd4, 1'b1, 6'd12, 1'b0, 6'd13, 12'h0);
        chk("R4 pending not issued", 32'(iss_valid), 0);
        tick(); idle();
        bcast(0, 6'd10, 1'b1);
        bcast(1, 6'd12, 1'b1);
        chk("R4 both pending", 32'(iss_valid), 0);
        tick(); idle();
        chk("R3 two woken", 32'(iss_valid), 32'b11);
        chk("R3 lane0 oldest", 32'(dst_of(0)), 11);
        chk("R3 lane1", 32'(dst_of(1)), 13);
        tick();
        chk("R6 drained", 32'(iss_valid), 0);
    endtask

    task automatic t_invalid_lane();
        put(5'd4, 6'd20, 1'b0, 6'd1, 1'b1, 6'd21, 12'h0);
        tick(); idle();
        bcast(0, 6'd20, 1'b0);
        tick(); idle();
        chk("R10 invalid lane ignored", 32'(iss_valid), 0);
        bcast(1, 6'd20, 1'b1);
        tick(); idle();
        chk("R3 lane1 wake", 32'(iss_valid), 32'b01);
        chk("R3 lane1 dst", 32'(dst_of(0)), 21);
        tick();
    endtask

    task automatic t_replay();
        put(5'd5, 6'd30, 1'b0, 6'd2, 1'b1, 6'd31, 12'h0);
        bcast(1, 6'd30, 1'b1);
        tick(); idle();
        chk("R7 not yet", 32'(iss_valid), 0);
        tick();
        chk("R7 replay wake", 32'(iss_valid), 32'b01);
        chk("R7 replay dst", 32'(dst_of(0)), 31);
        tick();
    endtask

    task automatic t_age();
        put(5'd6, 6'd1, 1'b1, 6'd2, 1'b1, 6'd50, 12'h0);   // slot 0
        tick();
        chk("R2 P issues", 32'(iss_valid), 32'b01);
        put(5'd7, 6'd51, 1'b0, 6'd2, 1'b1, 6'd52, 12'h0);  // slot 1
        tick();
        put(5'd8, 6'd51, 1'b0, 6'd2, 1'b1, 6'd53, 12'h0);  // slot 0, younger
        tick(); idle();
        bcast(0, 6'd51, 1'b1);
        tick(); idle();
        chk("R5 both", 32'(iss_valid), 32'b11);
        chk("R5 oldest on lane0", 32'(dst_of(0)), 52);
        chk("R5 younger on lane1", 32'(dst_of(1)), 53);
        chk("R5 lane0 slot", 32'(iss_slot[0 +: IDX_W]), 1);
        tick();
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) begin
            put(5'd9, 6'd60, 1'b0, 6'd2, 1'b1, 6'(40 + i), 12'h0);
            tick();
        end
        idle();
        chk("R8 full", 32'(disp_ready), 0);
        put(5'd10, 6'd1, 1'b1, 6'd2, 1'b1, 6'd63, 12'h0);
        tick(); idle();
        chk("R8 no issue", 32'(iss_valid), 0);
        bcast(0, 6'd60, 1'b1);
        tick(); idle();
        for (int c = 0; c < DEPTH / NGNT; c++) begin
            chk("R5 pair", 32'(iss_valid), 32'b11);
            chk("R5 order lane0", 32'(dst_of(0)), 32'(40 + 2 * c));
            chk("R5 order lane1", 32'(dst_of(1)), 32'(41 + 2 * c));
            tick();
        end
        chk("R8 discarded never issues", 32'(iss_valid), 0);
    endtask

    task automatic t_flush();
        put(5'd11, 6'd7, 1'b0, 6'd2, 1'b1, 6'd14, 12'h0);
        tick();
        put(5'd11, 6'd7, 1'b0, 6'd2, 1'b1, 6'd15, 12'h0);
        tick();
        put(5'd12, 6'd1, 1'b1, 6'd2, 1'b1, 6'd16, 12'h0);
        flush = 1'b1;
        tick(); idle();
        chk("R9 nothing issues", 32'(iss_valid), 0);
        chk("R9 ready", 32'(disp_ready), 1);
        bcast(0, 6'd7, 1'b1);
        tick(); idle();
        chk("R9 no wake after flush", 32'(iss_valid), 0);
        tick();
        chk("R9 still empty", 32'(iss_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_ready_dispatch();
        t_wakeup_two_lanes();
        t_invalid_lane();
        t_replay();
        t_age();
        t_full();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule